// File: doc/BRIEF.md
# Windowed Horizontal Sync Filter and Regenerator

This block cleans up a horizontal sync stream before it reaches line-locked logic. It measures the distance between successive accepted rising edges to learn the line period. Once it trusts that period, it opens an acceptance window of programmable half-width centred on the predicted edge. Rising edges that land outside the window are dropped, so equalization pulses and glitches never reach the filtered output.

When the window closes without an edge, the block marks the line as missing. It moves its timing reference to the predicted edge position and, on the regenerated output, inserts a pulse as wide as the last accepted one. A saturating miss score rises on every miss and falls on every accepted edge. Lock status is derived from this score.

Each output has its own enable. With its enable low, an output is simply the raw input delayed by one register.

Top module: `hsync_window_filter`

## Requirements
- R1: While reset is held and on the first cycle after it, `hs_filt`, `hs_regen`, `locked` and `miss_score` are all zero.
- R2: With `filt_en` low, `hs_filt` equals `hs_raw` as sampled one clock earlier.
- R3: With `regen_en` low, `hs_regen` equals `hs_raw` as sampled one clock earlier.
- R4: While unlocked, every rising edge (raw sampled high after a low sample) is accepted, and with `filt_en` high the pulse appears on `hs_filt` one clock later for its full width.
- R5: A consistent interval is one whose length in cycles is within `win_half` of the previous interval. `locked` rises two clocks after the edge that ends LOCK_RUN (default 4) consecutive consistent intervals, provided `miss_score` is zero.
- R6: While locked, a rising edge is discarded when its distance from the reference point differs from the learned period by more than `win_half`. A discarded edge produces no `hs_filt` pulse and leaves `miss_score` unchanged.
- R7: An in-window edge while locked is accepted. It lowers `miss_score` by one (floor 0), becomes the new reference point, and sets the learned period to the measured interval.
- R8: While locked, if no edge is accepted by the cycle in which the distance from the reference equals period plus `win_half`, `miss_score` rises by one (saturating). The reference point then moves to the predicted edge position.
- R9: With `regen_en` high, a miss drives `hs_regen` high from the next clock for as many cycles as the last accepted pulse was sampled high (1 before any pulse has been measured).
- R10: A miss that takes `miss_score` above LOSS_LIMIT (default 3) clears `locked` on the next clock.
- R11: With `filt_en` high, `hs_filt` carries only accepted pulses. With `regen_en` high, `hs_regen` carries the accepted pulses together with the inserted ones.
- R12: After lock is lost, `locked` stays low until `miss_score` has drained back to zero and a fresh run of LOCK_RUN consistent intervals has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_raw | input | 1 | Raw horizontal sync, active high |
| win_half | input | WIN_W | Half-width of the acceptance window in cycles |
| filt_en | input | 1 | Select windowed pulses on `hs_filt` |
| regen_en | input | 1 | Select windowed plus inserted pulses on `hs_regen` |
| hs_filt | output | 1 | Filtered sync |
| hs_regen | output | 1 | Regenerated sync |
| locked | output | 1 | Period lock status |
| miss_score | output | SCORE_W | Saturating miss/good score |

## Verification
The assertions assume that `hs_raw` is a clean single-bit level. They also assume that period plus `win_half` stays well below the saturation value of the phase counter, and that `win_half` is held constant while the block is locked.

The stimulus meets these assumptions in three ways. It uses a 40-cycle line with 4-cycle pulses and a half-width of 3. It changes the enables and the half-width only between lines. It applies uncorrelated random levels only in a segment that a reset closes.

Within the lines, the bench adds mid-line equalization pulses, an edge shifted inside the window, single and repeated missing lines, and resumption after loss of lock.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  // Is the measured distance within +/- win cycles of the predicted period?
  function automatic logic in_window(input int ph, input int per, input int win);
    return (ph >= per - win) && (ph <= per + win);
  endfunction

  // Has the window around the prediction just closed?
  function automatic logic window_closed(input int ph, input int per, input int win);
    return ph == per + win;
  endfunction
endpackage

// File: rtl/hsf_edge_track.sv
module hsf_edge_track #(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_raw,
  input  logic             accept,
  output logic             rise,
  output logic             trk,
  output logic [WID_W-1:0] width
);
  logic             hs_q;
  logic [WID_W-1:0] wcnt;

  assign rise = hs_raw & ~hs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      trk   <= 1'b0;
      wcnt  <= '0;
      width <= WID_W'(1);
    end else begin
      hs_q <= hs_raw;
      if (accept) begin
        trk  <= 1'b1;
        wcnt <= WID_W'(1);
      end else if (trk) begin
        if (hs_raw) begin
          wcnt <= (wcnt == '1) ? wcnt : wcnt + 1'b1;
        end else begin
          trk   <= 1'b0;
          width <= wcnt;
        end
      end
    end
  end
endmodule

// File: rtl/hsf_window_ctl.sv
module hsf_window_ctl #(
  parameter int PER_W      = 12,
  parameter int WIN_W      = 6,
  parameter int SCORE_W    = 4,
  parameter int LOCK_RUN   = 4,
  parameter int LOSS_LIMIT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rise,
  input  logic [WIN_W-1:0]   win_half,
  output logic               accept,
  output logic               miss,
  output logic               locked,
  output logic [SCORE_W-1:0] score
);
  localparam int RUN_W = $clog2(LOCK_RUN + 1);

  logic [PER_W-1:0] phase;
  logic [PER_W-1:0] period;
  logic             has_ref;
  logic [RUN_W-1:0] run;
  logic             in_win;
  logic             win_end;
  logic             loss;

  assign in_win  = hsf_pkg::in_window(int'(phase), int'(period), int'(win_half));
  assign win_end = hsf_pkg::window_closed(int'(phase), int'(period), int'(win_half));
  assign accept  = rise && (!locked || in_win);
  assign miss    = locked && !accept && win_end;
  assign loss    = miss && (int'(score) + 1 > LOSS_LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= '0;
      period  <= '0;
      has_ref <= 1'b0;
      run     <= '0;
      locked  <= 1'b0;
      score   <= '0;
    end else begin
      // timing reference
      if (accept) begin
        phase   <= PER_W'(1);
        has_ref <= 1'b1;
        if (has_ref) period <= phase;
      end else if (miss) begin
        phase <= PER_W'(int'(win_half) + 1);
      end else begin
        phase <= (phase == '1) ? phase : phase + 1'b1;
      end

      // miss/good score
      if (accept) begin
        score <= (score == '0) ? score : score - 1'b1;
      end else if (miss) begin
        score <= (score == '1) ? score : score + 1'b1;
      end

      // run of consistent intervals while acquiring
      if (!locked && accept) begin
        if (has_ref && period != '0 && in_win)
          run <= (int'(run) >= LOCK_RUN) ? run : run + 1'b1;
        else
          run <= '0;
      end

      // lock state
      if (!locked) begin
        if (int'(run) >= LOCK_RUN && score == '0) locked <= 1'b1;
      end else if (loss) begin
        locked <= 1'b0;
        run    <= '0;
      end
    end
  end
endmodule

// File: rtl/hsf_out_shape.sv
module hsf_out_shape #(
  parameter int WID_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_raw,
  input  logic             accept,
  input  logic             trk,
  input  logic             miss,
  input  logic [WID_W-1:0] width,
  input  logic             filt_en,
  input  logic             regen_en,
  output logic             hs_filt,
  output logic             hs_regen
);
  logic [WID_W-1:0] gen_left;
  logic             pass;

  assign pass = hs_raw && (accept || trk);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_left <= '0;
      hs_filt  <= 1'b0;
      hs_regen <= 1'b0;
    end else begin
      if (miss)
        gen_left <= width - 1'b1;
      else if (gen_left != '0)
        gen_left <= gen_left - 1'b1;
      hs_filt  <= filt_en  ? pass : hs_raw;
      hs_regen <= regen_en ? (pass || miss || gen_left != '0) : hs_raw;
    end
  end
endmodule

// File: rtl/hsync_window_filter.sv
module hsync_window_filter #(
  parameter int PER_W      = 12,
  parameter int WIN_W      = 6,
  parameter int WID_W      = 8,
  parameter int SCORE_W    = 4,
  parameter int LOCK_RUN   = 4,
  parameter int LOSS_LIMIT = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hs_raw,
  input  logic [WIN_W-1:0]   win_half,
  input  logic               filt_en,
  input  logic               regen_en,
  output logic               hs_filt,
  output logic               hs_regen,
  output logic               locked,
  output logic [SCORE_W-1:0] miss_score
);
  logic             rise_w;
  logic             trk_w;
  logic [WID_W-1:0] width_w;
  logic             acc_w;
  logic             miss_w;

  hsf_edge_track #(.WID_W(WID_W)) edge_i (
    .clk(clk), .rst_n(rst_n), .hs_raw(hs_raw), .accept(acc_w),
    .rise(rise_w), .trk(trk_w), .width(width_w)
  );

  hsf_window_ctl #(
    .PER_W(PER_W), .WIN_W(WIN_W), .SCORE_W(SCORE_W),
    .LOCK_RUN(LOCK_RUN), .LOSS_LIMIT(LOSS_LIMIT)
  ) win_i (
    .clk(clk), .rst_n(rst_n), .rise(rise_w), .win_half(win_half),
    .accept(acc_w), .miss(miss_w), .locked(locked), .score(miss_score)
  );

  hsf_out_shape #(.WID_W(WID_W)) out_i (
    .clk(clk), .rst_n(rst_n), .hs_raw(hs_raw), .accept(acc_w), .trk(trk_w),
    .miss(miss_w), .width(width_w), .filt_en(filt_en), .regen_en(regen_en),
    .hs_filt(hs_filt), .hs_regen(hs_regen)
  );
endmodule

// File: rtl/hsf_checker.sv
module hsf_checker #(
  parameter int SCORE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               hs_raw,
  input logic               filt_en,
  input logic               regen_en,
  input logic               hs_filt,
  input logic               hs_regen,
  input logic               locked,
  input logic [SCORE_W-1:0] miss_score,
  input logic               accept,
  input logic               miss
);
  logic [1:0] arm_cnt;
  logic       armed;

  always_ff @(posedge clk) begin
    if (!rst_n) arm_cnt <= '0;
    else if (arm_cnt != 2'd2) arm_cnt <= arm_cnt + 1'b1;
  end
  assign armed = (arm_cnt == 2'd2);

  // R2
  filt_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(filt_en) |-> hs_filt == $past(hs_raw));
  // R3
  regen_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !$past(regen_en) |-> hs_regen == $past(hs_raw));
  // R10
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $fell(locked) |-> $past(miss));
  // R12
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $rose(locked) |-> $past(miss_score) == '0);
  // R8
  score_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && (miss_score != $past(miss_score)) |-> ($past(accept) || $past(miss)));
  // R9
  regen_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(miss) && $past(regen_en) |-> hs_regen);
  // R11
  filt_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $rose(hs_filt) && $past(filt_en) |-> $past(accept));
endmodule

bind hsync_window_filter hsf_checker #(.SCORE_W(SCORE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .hs_raw(hs_raw), .filt_en(filt_en),
  .regen_en(regen_en), .hs_filt(hs_filt), .hs_regen(hs_regen),
  .locked(locked), .miss_score(miss_score), .accept(acc_w), .miss(miss_w)
);

// File: tb/hsync_window_filter_tb_top.sv
`timescale 1ns/1ps
module hsync_window_filter_tb_top;
  localparam int PER_W = 12, WIN_W = 6, WID_W = 8, SCORE_W = 4;
  localparam int LOCK_RUN = 4, LOSS_LIMIT = 3;
  localparam int LINE = 40, PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_raw = 1'b0;
  logic [WIN_W-1:0] win_half = 6'd3;
  logic filt_en = 1'b0, regen_en = 1'b0;
  logic hs_filt, hs_regen, locked;
  logic [SCORE_W-1:0] miss_score;

  always #5 clk = ~clk;

  hsync_window_filter #(.PER_W(PER_W), .WIN_W(WIN_W), .WID_W(WID_W), .SCORE_W(SCORE_W),
    .LOCK_RUN(LOCK_RUN), .LOSS_LIMIT(LOSS_LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .hs_raw(hs_raw), .win_half(win_half),
    .filt_en(filt_en), .regen_en(regen_en), .hs_filt(hs_filt),
    .hs_regen(hs_regen), .locked(locked), .miss_score(miss_score));

  int n_vec = 0, n_bad = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_prev, m_phase, m_period, m_run, m_score, m_wcnt, m_width, m_gen;
  bit m_hasref, m_locked, m_trk, e_filt, e_regen;

  task automatic model_reset();
    m_prev = 0; m_phase = 0; m_period = 0; m_run = 0; m_score = 0;
    m_wcnt = 0; m_width = 1; m_gen = 0; m_hasref = 0; m_locked = 0; m_trk = 0;
    e_filt = 0; e_regen = 0;
  endtask

  task automatic model_step();
    int w;
    bit rise, inwin, acc, miss, pass, lose, nlocked;
    w = int'(win_half);
    rise  = hs_raw && (m_prev == 0);
    inwin = (m_phase >= m_period - w) && (m_phase <= m_period + w);
    acc   = rise && (!m_locked || inwin);
    miss  = m_locked && !acc && (m_phase == m_period + w);
    pass  = hs_raw && (acc || m_trk);
    e_filt  = filt_en ? pass : hs_raw;
    e_regen = regen_en ? (pass || miss || m_gen > 0) : hs_raw;
    if (miss) m_gen = m_width - 1; else if (m_gen > 0) m_gen--;
    if (acc) begin m_trk = 1; m_wcnt = 1; end
    else if (m_trk) begin
      if (hs_raw) m_wcnt = (m_wcnt < 255) ? m_wcnt + 1 : 255;
      else begin m_trk = 0; m_width = m_wcnt; end
    end
    lose = miss && (m_score + 1 > LOSS_LIMIT);
    nlocked = m_locked;
    if (!m_locked) begin
      if (m_run >= LOCK_RUN && m_score == 0) nlocked = 1;
    end else if (lose) nlocked = 0;
    if (!m_locked && acc)
      m_run = (m_hasref && m_period != 0 && inwin) ? ((m_run < LOCK_RUN) ? m_run + 1 : m_run) : 0;
    if (lose) m_run = 0;
    if (acc) m_score = (m_score > 0) ? m_score - 1 : 0;
    else if (miss) m_score = (m_score < 15) ? m_score + 1 : 15;
    if (acc) begin
      if (m_hasref) m_period = m_phase;
      m_phase = 1; m_hasref = 1;
    end else if (miss) m_phase = w + 1;
    else if (m_phase < 4095) m_phase++;
    m_locked = nlocked;
    m_prev = hs_raw;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(bit raw);
    hs_raw = raw;
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk(cur_req, "hs_filt", int'(hs_filt), int'(e_filt));
    chk(cur_req, "hs_regen", int'(hs_regen), int'(e_regen));
    chk(cur_req, "locked", int'(locked), int'(m_locked));
    chk(cur_req, "miss_score", int'(miss_score), m_score);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; hs_raw = 0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared while reset is held
    chk("R1", "hs_filt", int'(hs_filt), 0);
    chk("R1", "hs_regen", int'(hs_regen), 0);
    chk("R1", "locked", int'(locked), 0);
    chk("R1", "miss_score", int'(miss_score), 0);
    rst_n = 1;
    model_reset();
  endtask

  // one line: sync pulse at cycle 0 (optional), extra pulse of 2 at 'eq' (if > 0)
  task automatic line(int len, bit pulse, int eq);
    for (int c = 0; c < len; c++)
      tick((pulse && c < PW) || (eq > 0 && c >= eq && c < eq + 2));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    cur_req = "R1";
    tick(0);

    // R2 R3: bypass on both outputs with random raw levels
    cur_req = "R2_R3";
    for (int i = 0; i < 60; i++) tick(1'($urandom));
    do_reset();

    // R4 R5: acquisition with filtering and regeneration on
    filt_en = 1; regen_en = 1;
    cur_req = "R4_R5";
    for (int i = 0; i < 8; i++) line(LINE, 1, 0);
    chk("R5", "locked after training", int'(locked), 1);

    // R6: mid-line equalization pulses discarded
    cur_req = "R6";
    line(LINE, 1, 20);
    line(LINE, 1, 12);
    chk("R6", "score after eq pulses", int'(miss_score), 0);
    chk("R6", "still locked", int'(locked), 1);

    // R8 R9: one missing line, regenerated pulse inserted
    cur_req = "R8_R9";
    line(LINE, 0, 0);
    chk("R8", "score after miss", int'(miss_score), 1);
    // R7: in-window shifted edge accepted, score drains
    cur_req = "R7";
    line(LINE + 2, 1, 0);
    chk("R7", "score after good edge", int'(miss_score), 0);
    line(LINE, 1, 0);
    line(LINE, 1, 0);

    // R3 R11: regeneration off while filtering, with a miss and an eq pulse
    cur_req = "R3_R11";
    regen_en = 0;
    line(LINE, 1, 20);
    line(LINE, 0, 0);
    line(LINE, 1, 0);
    regen_en = 1;
    line(LINE, 1, 0);

    // R10: repeated missing lines lose lock
    cur_req = "R10";
    for (int i = 0; i < 5; i++) line(LINE, 0, 0);
    chk("R10", "locked after misses", int'(locked), 0);
    chk("R10", "score after misses", int'(miss_score), LOSS_LIMIT + 1);

    // R12: relock only after score drains and a new run completes
    cur_req = "R12";
    for (int i = 0; i < 3; i++) line(LINE, 1, 0);
    chk("R12", "not yet relocked", int'(locked), 0);
    for (int i = 0; i < 6; i++) line(LINE, 1, 0);
    chk("R12", "relocked", int'(locked), 1);

    // R2: filter off while locked
    cur_req = "R2";
    filt_en = 0;
    line(LINE, 1, 20);
    filt_en = 1;
    line(LINE, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule